// File: doc/BRIEF.md
# Register window index mapper

This block turns an architectural integer register number into an index into a flat physical register file. The machine it serves has rotating register windows and several banks of global registers. The core holds two pieces of state: a current window pointer and a global level. From these and one architectural index, the block produces three physical indices at once. One is for the current window, one for the next window (pointer minus one) and one for the previous window (pointer plus one). Save and restore paths can therefore read an adjacent window without waiting for the pointer to move.

The architectural index space has three parts, in this order. First come the global registers. Next come the windowed registers visible from one window, which are the window's own registers plus the half window it shares with a neighbour. Last come the micro-op scratch registers. Global register 0 is a hard zero and always selects physical entry 0. The other globals are banked by level. Windowed registers wrap modulo the total windowed storage. Scratch registers sit after all globals and all windowed storage. A write of the window pointer that is out of range saturates at the last window. The mapping is combinational from the two state registers and the index, so a write shows up in the cycle after it.

Top module: `rwm_index_mapper`

## Requirements
- R1: While rst_ni is low, cwp_o and gl_o are 0.
- R2: Architectural index 0 gives physical index 0 in all three views, at every global level, with idx_valid_o high.
- R3: Architectural index i with 1 <= i < N_GLOB gives i + gl_o*N_GLOB, and the value is the same in all three views.
- R4: Architectural index N_GLOB+j with 0 <= j < RPW*3/2 gives, in the current view, N_GL*N_GLOB + ((j - cwp_o*RPW) mod (N_WIN*RPW)).
- R5: The next view applies the R4 formula with pointer (cwp_o-1) mod N_WIN. The previous view applies it with (cwp_o+1) mod N_WIN.
- R6: A pointer write (cwp_we_i high at a rising edge) loads cwp_wdata_i if it is below N_WIN and loads N_WIN-1 otherwise. The new value appears on cwp_o after that edge.
- R7: A level write (gl_we_i high) loads gl_wdata_i after that edge. A register whose write enable is low keeps its value, including when only the other register is written.
- R8: Architectural index N_GLOB+RPW*3/2+k with 0 <= k < N_MICRO gives N_GL*N_GLOB + N_WIN*RPW + k in all three views.
- R9: Any architectural index at or above N_GLOB+RPW*3/2+N_MICRO drives idx_valid_o low and all three physical outputs to 0. Every index below that drives idx_valid_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cwp_we_i | input | 1 | Window pointer write enable |
| cwp_wdata_i | input | CWP_IN_W | Window pointer write value, before clamping |
| gl_we_i | input | 1 | Global level write enable |
| gl_wdata_i | input | GL_W | Global level write value |
| arch_idx_i | input | ARCH_W | Architectural register index |
| cwp_o | output | CWP_W | Current window pointer |
| gl_o | output | GL_W | Current global level |
| cur_phys_o | output | PHYS_W | Physical index for the current window view |
| nxt_phys_o | output | PHYS_W | Physical index for the next window view |
| prv_phys_o | output | PHYS_W | Physical index for the previous window view |
| idx_valid_o | output | 1 | Architectural index is inside the mapped space |

## Verification
The assertions check several properties on every cycle. They check that the pointer saturates and that both state registers hold when not written. They check the zero pin of global 0, that the three views agree for globals and scratch registers, and that the next and previous window results sit exactly one window stride either side of the current result. Only the bench's scenarios show the absolute values. These are the banked global offsets at each level, the rotated window position for every pointer, the scratch base, and return to zero on a reset in mid-run. For these, the bench sweeps every index at every pointer and level, then runs random write and lookup traffic against its own model.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

  typedef enum logic [1:0] {
    RGN_GLOBAL,
    RGN_WINDOW,
    RGN_MICRO,
    RGN_NONE
  } rgn_e;

  localparam int DEF_N_WIN   = 8;
  localparam int DEF_RPW     = 16;
  localparam int DEF_N_GL    = 4;
  localparam int DEF_N_GLOB  = 8;
  localparam int DEF_N_MICRO = 8;

endpackage

// File: rtl/rwm_state.sv
module rwm_state #(
  parameter int N_WIN    = 8,
  parameter int CWP_IN_W = 5,
  parameter int CWP_W    = 3,
  parameter int GL_W     = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cwp_we_i,
  input  logic [CWP_IN_W-1:0] cwp_wdata_i,
  input  logic                gl_we_i,
  input  logic [GL_W-1:0]     gl_wdata_i,
  output logic [CWP_W-1:0]    cwp_o,
  output logic [GL_W-1:0]     gl_o
);

  logic [CWP_W-1:0] cwp_clamped;

  // saturate out-of-range pointer writes at the last window
  always_comb begin
    if (cwp_wdata_i >= CWP_IN_W'(N_WIN)) cwp_clamped = CWP_W'(N_WIN - 1);
    else                                 cwp_clamped = cwp_wdata_i[CWP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_o <= '0;
    end else if (cwp_we_i) begin
      cwp_o <= cwp_clamped;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gl_o <= '0;
    end else if (gl_we_i) begin
      gl_o <= gl_wdata_i;
    end
  end

endmodule

// File: rtl/rwm_decode.sv
module rwm_decode
  import rwm_pkg::*;
#(
  parameter int N_GLOB   = 8,
  parameter int VIEW_WIN = 24,
  parameter int N_MICRO  = 8,
  parameter int ARCH_W   = 6
) (
  input  logic [ARCH_W-1:0] arch_idx_i,
  output rgn_e              rgn_o,
  output logic [ARCH_W-1:0] off_o
);

  localparam int WIN_LO = N_GLOB;
  localparam int MIC_LO = N_GLOB + VIEW_WIN;
  localparam int TOP_N  = MIC_LO + N_MICRO;

  always_comb begin
    if (arch_idx_i < ARCH_W'(WIN_LO)) begin
      rgn_o = RGN_GLOBAL;
      off_o = arch_idx_i;
    end else if (arch_idx_i < ARCH_W'(MIC_LO)) begin
      rgn_o = RGN_WINDOW;
      off_o = arch_idx_i - ARCH_W'(WIN_LO);
    end else if (arch_idx_i < ARCH_W'(TOP_N)) begin
      rgn_o = RGN_MICRO;
      off_o = arch_idx_i - ARCH_W'(MIC_LO);
    end else begin
      rgn_o = RGN_NONE;
      off_o = '0;
    end
  end

endmodule

// File: rtl/rwm_view.sv
module rwm_view
  import rwm_pkg::*;
#(
  parameter int N_GLOB = 8,
  parameter int TG     = 32,
  parameter int CWP_W  = 3,
  parameter int RPW_W  = 4,
  parameter int GL_W   = 2,
  parameter int ARCH_W = 6,
  parameter int PHYS_W = 8,
  parameter int DELTA  = 0
) (
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [GL_W-1:0]   gl_i,
  input  rgn_e              rgn_i,
  input  logic [ARCH_W-1:0] off_i,
  output logic [PHYS_W-1:0] phys_o
);

  localparam int TW_W = CWP_W + RPW_W;
  localparam int TW   = 1 << TW_W;

  logic [CWP_W-1:0] cwp_v;
  logic [TW_W-1:0]  win_off;

  // view pointer wraps modulo the window count by truncation
  assign cwp_v   = cwp_i + CWP_W'(DELTA);
  assign win_off = TW_W'(off_i) - {cwp_v, {RPW_W{1'b0}}};

  always_comb begin
    unique case (rgn_i)
      RGN_GLOBAL: begin
        if (off_i == '0) phys_o = '0;
        else phys_o = PHYS_W'(gl_i) * PHYS_W'(N_GLOB) + PHYS_W'(off_i);
      end
      RGN_WINDOW: phys_o = PHYS_W'(TG) + PHYS_W'(win_off);
      RGN_MICRO:  phys_o = PHYS_W'(TG) + PHYS_W'(TW) + PHYS_W'(off_i);
      default:    phys_o = '0;
    endcase
  end

endmodule

// File: rtl/rwm_index_mapper.sv
module rwm_index_mapper
  import rwm_pkg::*;
#(
  parameter int N_WIN    = DEF_N_WIN,
  parameter int RPW      = DEF_RPW,
  parameter int N_GL     = DEF_N_GL,
  parameter int N_GLOB   = DEF_N_GLOB,
  parameter int N_MICRO  = DEF_N_MICRO,
  parameter int CWP_IN_W = 5,
  localparam int CWP_W    = $clog2(N_WIN),
  localparam int GL_W     = $clog2(N_GL),
  localparam int RPW_W    = $clog2(RPW),
  localparam int VIEW_WIN = RPW + RPW / 2,
  localparam int TG       = N_GL * N_GLOB,
  localparam int TW       = N_WIN * RPW,
  localparam int ARCH_N   = N_GLOB + VIEW_WIN + N_MICRO,
  localparam int ARCH_W   = $clog2(ARCH_N + 1),
  localparam int PHYS_N   = TG + TW + N_MICRO,
  localparam int PHYS_W   = $clog2(PHYS_N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cwp_we_i,
  input  logic [CWP_IN_W-1:0] cwp_wdata_i,
  input  logic                gl_we_i,
  input  logic [GL_W-1:0]     gl_wdata_i,
  input  logic [ARCH_W-1:0]   arch_idx_i,
  output logic [CWP_W-1:0]    cwp_o,
  output logic [GL_W-1:0]     gl_o,
  output logic [PHYS_W-1:0]   cur_phys_o,
  output logic [PHYS_W-1:0]   nxt_phys_o,
  output logic [PHYS_W-1:0]   prv_phys_o,
  output logic                idx_valid_o
);

  localparam int N_VIEWS = 3;

  rgn_e              rgn;
  logic [ARCH_W-1:0] off;
  logic [PHYS_W-1:0] phys_v [N_VIEWS];

  rwm_state #(
    .N_WIN   (N_WIN),
    .CWP_IN_W(CWP_IN_W),
    .CWP_W   (CWP_W),
    .GL_W    (GL_W)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cwp_we_i   (cwp_we_i),
    .cwp_wdata_i(cwp_wdata_i),
    .gl_we_i    (gl_we_i),
    .gl_wdata_i (gl_wdata_i),
    .cwp_o      (cwp_o),
    .gl_o       (gl_o)
  );

  rwm_decode #(
    .N_GLOB  (N_GLOB),
    .VIEW_WIN(VIEW_WIN),
    .N_MICRO (N_MICRO),
    .ARCH_W  (ARCH_W)
  ) u_decode (
    .arch_idx_i(arch_idx_i),
    .rgn_o     (rgn),
    .off_o     (off)
  );

  // view 0 current, view 1 next (pointer-1), view 2 previous (pointer+1)
  for (genvar v = 0; v < N_VIEWS; v++) begin : g_view
    localparam int STEP = (v == 0) ? 0 : ((v == 1) ? -1 : 1);
    rwm_view #(
      .N_GLOB(N_GLOB),
      .TG    (TG),
      .CWP_W (CWP_W),
      .RPW_W (RPW_W),
      .GL_W  (GL_W),
      .ARCH_W(ARCH_W),
      .PHYS_W(PHYS_W),
      .DELTA (STEP)
    ) u_view (
      .cwp_i (cwp_o),
      .gl_i  (gl_o),
      .rgn_i (rgn),
      .off_i (off),
      .phys_o(phys_v[v])
    );
  end

  assign cur_phys_o  = phys_v[0];
  assign nxt_phys_o  = phys_v[1];
  assign prv_phys_o  = phys_v[2];
  assign idx_valid_o = (rgn != RGN_NONE);

endmodule

// File: rtl/rwm_checker.sv
module rwm_checker #(
  parameter int N_WIN    = 8,
  parameter int RPW      = 16,
  parameter int N_GL     = 4,
  parameter int N_GLOB   = 8,
  parameter int N_MICRO  = 8,
  parameter int CWP_IN_W = 5,
  localparam int CWP_W    = $clog2(N_WIN),
  localparam int GL_W     = $clog2(N_GL),
  localparam int RPW_W    = $clog2(RPW),
  localparam int VIEW_WIN = RPW + RPW / 2,
  localparam int TG       = N_GL * N_GLOB,
  localparam int TW_W     = CWP_W + RPW_W,
  localparam int ARCH_N   = N_GLOB + VIEW_WIN + N_MICRO,
  localparam int ARCH_W   = $clog2(ARCH_N + 1),
  localparam int PHYS_N   = TG + N_WIN * RPW + N_MICRO,
  localparam int PHYS_W   = $clog2(PHYS_N)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cwp_we_i,
  input logic [CWP_IN_W-1:0] cwp_wdata_i,
  input logic                gl_we_i,
  input logic [GL_W-1:0]     gl_wdata_i,
  input logic [ARCH_W-1:0]   arch_idx_i,
  input logic [CWP_W-1:0]    cwp_o,
  input logic [GL_W-1:0]     gl_o,
  input logic [PHYS_W-1:0]   cur_phys_o,
  input logic [PHYS_W-1:0]   nxt_phys_o,
  input logic [PHYS_W-1:0]   prv_phys_o,
  input logic                idx_valid_o
);

  logic in_glob, in_win, in_mic, in_none;
  logic [TW_W-1:0] cur_w, nxt_w, prv_w;

  assign in_glob = arch_idx_i < ARCH_W'(N_GLOB);
  assign in_win  = !in_glob && (arch_idx_i < ARCH_W'(N_GLOB + VIEW_WIN));
  assign in_mic  = !in_glob && !in_win && (arch_idx_i < ARCH_W'(ARCH_N));
  assign in_none = arch_idx_i >= ARCH_W'(ARCH_N);
  assign cur_w   = TW_W'(cur_phys_o - PHYS_W'(TG));
  assign nxt_w   = TW_W'(nxt_phys_o - PHYS_W'(TG));
  assign prv_w   = TW_W'(prv_phys_o - PHYS_W'(TG));

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (cwp_o == '0) && (gl_o == '0));

  assert_glob0_pinned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arch_idx_i == '0) |-> idx_valid_o && (cur_phys_o == '0) && (nxt_phys_o == '0) && (prv_phys_o == '0));

  assert_glob_views_agree_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_glob |-> (cur_phys_o == nxt_phys_o) && (cur_phys_o == prv_phys_o));

  assert_win_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |-> (cur_phys_o >= PHYS_W'(TG)) && (cur_phys_o < PHYS_W'(TG + N_WIN * RPW)));

  assert_view_stride_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |-> (nxt_w == cur_w + TW_W'(RPW)) && (prv_w == cur_w - TW_W'(RPW)));

  assert_cwp_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_we_i && (cwp_wdata_i >= CWP_IN_W'(N_WIN)) |=> (cwp_o == CWP_W'(N_WIN - 1)));

  assert_cwp_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_we_i && (cwp_wdata_i < CWP_IN_W'(N_WIN)) |=> (cwp_o == $past(cwp_wdata_i[CWP_W-1:0])));

  assert_cwp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cwp_we_i |=> $stable(cwp_o));

  assert_gl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gl_we_i |=> $stable(gl_o));

  assert_gl_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gl_we_i |=> (gl_o == $past(gl_wdata_i)));

  assert_micro_views_agree_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_mic |-> (cur_phys_o == nxt_phys_o) && (cur_phys_o == prv_phys_o) && idx_valid_o);

  assert_out_of_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_none |-> !idx_valid_o && (cur_phys_o == '0) && (nxt_phys_o == '0) && (prv_phys_o == '0));

endmodule

bind rwm_index_mapper rwm_checker #(
  .N_WIN   (N_WIN),
  .RPW     (RPW),
  .N_GL    (N_GL),
  .N_GLOB  (N_GLOB),
  .N_MICRO (N_MICRO),
  .CWP_IN_W(CWP_IN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cwp_we_i   (cwp_we_i),
  .cwp_wdata_i(cwp_wdata_i),
  .gl_we_i    (gl_we_i),
  .gl_wdata_i (gl_wdata_i),
  .arch_idx_i (arch_idx_i),
  .cwp_o      (cwp_o),
  .gl_o       (gl_o),
  .cur_phys_o (cur_phys_o),
  .nxt_phys_o (nxt_phys_o),
  .prv_phys_o (prv_phys_o),
  .idx_valid_o(idx_valid_o)
);

// File: tb/sim_rwm_index_mapper.sv
`timescale 1ns/1ps
module sim_rwm_index_mapper;

  localparam int N_WIN = 8, RPW = 16, N_GL = 4, N_GLOB = 8, N_MICRO = 8, CWP_IN_W = 5;
  localparam int VW = RPW + RPW / 2;
  localparam int TG = N_GL * N_GLOB;
  localparam int TW = N_WIN * RPW;
  localparam int ARCH_N = N_GLOB + VW + N_MICRO;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cwp_we_i = 1'b0;
  logic [4:0] cwp_wdata_i = '0;
  logic       gl_we_i = 1'b0;
  logic [1:0] gl_wdata_i = '0;
  logic [5:0] arch_idx_i = '0;
  logic [2:0] cwp_o;
  logic [1:0] gl_o;
  logic [7:0] cur_phys_o, nxt_phys_o, prv_phys_o;
  logic       idx_valid_o;

  int checks = 0, errors = 0;
  int m_cwp = 0, m_gl = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rwm_index_mapper #(
    .N_WIN(N_WIN), .RPW(RPW), .N_GL(N_GL), .N_GLOB(N_GLOB),
    .N_MICRO(N_MICRO), .CWP_IN_W(CWP_IN_W)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cwp_we_i(cwp_we_i), .cwp_wdata_i(cwp_wdata_i),
    .gl_we_i(gl_we_i), .gl_wdata_i(gl_wdata_i), .arch_idx_i(arch_idx_i),
    .cwp_o(cwp_o), .gl_o(gl_o), .cur_phys_o(cur_phys_o), .nxt_phys_o(nxt_phys_o),
    .prv_phys_o(prv_phys_o), .idx_valid_o(idx_valid_o)
  );

  function automatic int exp_phys(int cwp, int gl, int idx);
    if (idx < N_GLOB) return (idx == 0) ? 0 : idx + gl * N_GLOB;
    if (idx < N_GLOB + VW) begin
      int j = idx - N_GLOB;
      return TG + ((((j - cwp * RPW) % TW) + TW) % TW);
    end
    if (idx < ARCH_N) return TG + TW + (idx - N_GLOB - VW);
    return 0;
  endfunction

  function automatic string tag_of(int idx);
    if (idx == 0) return "R2";
    if (idx < N_GLOB) return "R3";
    if (idx < N_GLOB + VW) return "R4";
    if (idx < ARCH_N) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cwp=%0d gl=%0d idx=%0d)",
               tag, what, act, exp, m_cwp, m_gl, arch_idx_i);
    end
  endtask

  task automatic do_write(bit cwe, int cval, bit gwe, int gval);
    @(negedge clk_i);
    cwp_we_i = cwe; cwp_wdata_i = 5'(cval);
    gl_we_i  = gwe; gl_wdata_i  = 2'(gval);
    @(posedge clk_i); #1;
    if (cwe) m_cwp = (cval >= N_WIN) ? N_WIN - 1 : cval;
    if (gwe) m_gl = gval;
    cwp_we_i = 1'b0; gl_we_i = 1'b0;
    check(cwe ? "R6" : "R7", "cwp_o", int'(cwp_o), m_cwp);
    check("R7", "gl_o", int'(gl_o), m_gl);
  endtask

  task automatic probe(int idx);
    string t;
    @(negedge clk_i);
    arch_idx_i = 6'(idx);
    #1;
    t = tag_of(idx);
    check(t, "cur_phys_o", int'(cur_phys_o), exp_phys(m_cwp, m_gl, idx));
    check((idx >= N_GLOB && idx < N_GLOB + VW) ? "R5" : t, "nxt_phys_o",
          int'(nxt_phys_o), exp_phys((m_cwp + N_WIN - 1) % N_WIN, m_gl, idx));
    check((idx >= N_GLOB && idx < N_GLOB + VW) ? "R5" : t, "prv_phys_o",
          int'(prv_phys_o), exp_phys((m_cwp + 1) % N_WIN, m_gl, idx));
    check("R9", "idx_valid_o", int'(idx_valid_o), (idx < ARCH_N) ? 1 : 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", "cwp_o in reset", int'(cwp_o), 0);
    check("R1", "gl_o in reset", int'(gl_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // directed sweep: every pointer and level, every index
    for (int c = 0; c < N_WIN; c++) begin
      for (int g = 0; g < N_GL; g++) begin
        do_write(1'b1, c, 1'b1, g);
        for (int i = 0; i < 64; i++) probe(i);
      end
    end

    // R6 clamp corners
    do_write(1'b1, N_WIN, 1'b0, 0);
    probe(N_GLOB);
    do_write(1'b1, 31, 1'b0, 0);
    do_write(1'b1, 0, 1'b0, 0);
    do_write(1'b1, N_WIN - 1, 1'b0, 0);
    do_write(1'b1, 17, 1'b0, 0);
    probe(N_GLOB + VW - 1);

    // R7: only one register written, other holds
    do_write(1'b1, 3, 1'b1, 2);
    do_write(1'b0, 6, 1'b1, 1);
    do_write(1'b1, 5, 1'b0, 3);
    do_write(1'b0, 0, 1'b0, 0);
    probe(1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      do_write(1'($urandom % 2), int'($urandom % 32), 1'($urandom % 2), int'($urandom % 4));
      probe(int'($urandom % 64));
    end

    // R1: reset in mid-run returns state to zero
    do_write(1'b1, 6, 1'b1, 3);
    @(negedge clk_i) rst_ni = 1'b0;
    #2;
    m_cwp = 0; m_gl = 0;
    check("R1", "cwp_o after mid reset", int'(cwp_o), 0);
    check("R1", "gl_o after mid reset", int'(gl_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    probe(N_GLOB + 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule